// File: doc/BRIEF.md
# Phase-Aligned Ratio Clock Divider Bank

This block turns one fast master clock into a family of related clock levels for a processor board: a processor-rate clock, a half-rate copy, a graphics-port clock, a peripheral-bus clock and an interrupt-controller clock. It also produces the enable and test controls for a fixed 48 MHz output and passes a reference clock through. The master clock runs at twice the processor rate. Every derived output rises on the same master edge as a processor-clock rising edge, so the whole family stays phase aligned.

A three-bit select picks one of two ratio families, a reference-driven test mode, or a quiet mode in which all drivers are released. The two families are a "quarter" family (half, quarter and eighth of the processor rate) and a "third" family (half, two thirds, third and sixth). The block holds the select in a register. It applies a new mode only at the end of the current counter period, so no output ever produces a shortened pulse.

The controller is a four-state machine. HIZ is the quiet state, with drivers released and all levels low. THIRD runs with a 12-phase counter. QUARTER runs with a 16-phase counter. REFTEST runs a 16-phase counter that advances on synchronized rising edges of the reference input. HIZ moves to the decoded mode on the next edge. THIRD, QUARTER and REFTEST each move to the decoded mode only on the edge that wraps their counter back to phase 0. When that edge arrives with an unchanged select, the state stays where it is and the counter restarts.

Top module: `clkdiv_bank`

## Requirements
- R1: While `rst_n` is low, all five clock outputs, `core_oe` and `usb48_oe` are low, and the phase counter restarts at 0.
- R2: When the applied mode is quiet (select 000), `core_oe` and `usb48_oe` are low and all clock outputs and `ref_out` are low.
- R3: In the quarter family (select 101, 110, 111), with the phase `c` counting 0..15 on master rising edges: `cpu_clk` is high when c is even, `cpu_half` and `gfx_clk` are high when c mod 4 < 2, `pci_clk` is high when c mod 8 < 4, and `apic_clk` is high when c < 8.
- R4: In the third family (select 001, 010, 011), with c counting 0..11: `cpu_clk` is high when c is even, `cpu_half` is high when c mod 4 < 2, `pci_clk` is high when c mod 6 < 3, and `apic_clk` is high when c < 6.
- R5: In the third family, `gfx_clk` rises on the master rising edge of phases 0, 3, 6 and 9. It falls on the master falling edge one and a half master cycles later, which gives a 50% duty at one third of the master rate.
- R6: Every rising edge of `cpu_half`, `pci_clk` and `apic_clk` coincides with a rising edge of `cpu_clk`, and at phase 0 all five clocks are high.
- R7: In the two run families, `usb48_oe` equals bit 0 of the applied select code.
- R8: In test mode (select 100), the counter advances once per synchronized rising edge of `ref_in`. `cpu_clk` and `usb48_tclk` run at REF/2, `cpu_half` and `gfx_clk` at REF/4, `pci_clk` at REF/8 and `apic_clk` at REF/16. `usb48_byp`, `usb48_oe` and `core_oe` are high.
- R9: In any mode other than quiet, `core_oe` is high and `ref_out` follows `ref_in`.
- R10: The select is registered on every master edge. From the quiet state, the new mode takes effect on the second edge after the select changes, starting at phase 0. From a running mode, the new mode takes effect on the edge that wraps the counter to phase 0.
- R11: If a select change is first present during the last phase of a period, it waits one further full period before it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Mode select {family, b1, b0} |
| ref_in | input | 1 | Reference clock, used for pass-through and test mode |
| cpu_clk | output | 1 | Processor-rate clock level |
| cpu_half | output | 1 | Half processor-rate clock level |
| gfx_clk | output | 1 | Graphics-port clock level |
| pci_clk | output | 1 | Peripheral-bus clock level |
| apic_clk | output | 1 | Interrupt-controller clock level |
| ref_out | output | 1 | Reference pass-through |
| core_oe | output | 1 | Driver enable for the clock and reference outputs |
| usb48_oe | output | 1 | Driver enable for the 48 MHz output |
| usb48_byp | output | 1 | High when the 48 MHz pin must carry `usb48_tclk` instead |
| usb48_tclk | output | 1 | Test-mode level for the 48 MHz pin |

## Verification
Both run families are checked phase by phase against a ratio model over more than one full period. In the third family, the graphics clock is also checked at a half-cycle sample point, which separates a true one-and-a-half-cycle high time from a whole-cycle one. The bench changes the select in the middle of a period, in its last phase and toward quiet. These cases show whether a mode is applied on the wrap edge, one period late, or too early. In test mode, a fixed number of reference pulses must produce exact rising-edge counts on every output and return the counter to phase 0. This separates correct reference ticking from master-clock counting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PH_W = 4;
    localparam logic [PH_W-1:0] LAST_QUAD = PH_W'(15);
    localparam logic [PH_W-1:0] LAST_TRI  = PH_W'(11);

    typedef enum logic [1:0] {
        MODE_HIZ,
        MODE_THIRD,
        MODE_QUARTER,
        MODE_REFTEST
    } mode_e;

    typedef struct packed {
        logic cpu;
        logic half;
        logic gfx;
        logic pci;
        logic apic;
    } taps_t;

    // Select code to mode: 000 quiet, 100 reference test, else bit 2 picks family.
    function automatic mode_e sel_to_mode(input logic [2:0] s);
        mode_e m;
        case (s)
            3'b000:  m = MODE_HIZ;
            3'b100:  m = MODE_REFTEST;
            default: m = s[2] ? MODE_QUARTER : MODE_THIRD;
        endcase
        return m;
    endfunction

    // Output levels for a given mode at phase c (posedge-registered part only).
    function automatic taps_t taps_at(input mode_e m, input logic [PH_W-1:0] c);
        taps_t t;
        t = '0;
        unique case (m)
            MODE_HIZ: t = '0;
            MODE_THIRD: begin
                t.cpu  = ~c[0];
                t.half = ~c[1];
                t.gfx  = (c % PH_W'(3)) == PH_W'(0);
                t.pci  = (c % PH_W'(6)) < PH_W'(3);
                t.apic = c < PH_W'(6);
            end
            MODE_QUARTER, MODE_REFTEST: begin
                t.cpu  = ~c[0];
                t.half = ~c[1];
                t.gfx  = ~c[1];
                t.pci  = ~c[2];
                t.apic = ~c[3];
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/clkdiv_refsync.sv
module clkdiv_refsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            last_q <= 1'b0;
        end else begin
            sh     <= {sh[STAGES-2:0], ref_in};
            last_q <= sh[STAGES-1];
        end
    end

    assign rise = sh[STAGES-1] & ~last_q;
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel,
    input  logic            ref_rise,
    output mode_e           mode,
    output mode_e           mode_nx,
    output logic [PH_W-1:0] ph_nx,
    output logic            en48
);
    logic [2:0]      sel_q;
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] last;
    logic            adv;
    logic            wrap;
    logic            realign;

    // Per-state counting behaviour.
    always_comb begin
        last = (mode == MODE_THIRD) ? LAST_TRI : LAST_QUAD;
        unique case (mode)
            MODE_HIZ:                 adv = 1'b0;
            MODE_THIRD, MODE_QUARTER: adv = 1'b1;
            MODE_REFTEST:             adv = ref_rise;
        endcase
        wrap    = adv && (ph == last);
        realign = (mode == MODE_HIZ) || wrap;
        if (realign)
            ph_nx = '0;
        else if (adv)
            ph_nx = ph + 1'b1;
        else
            ph_nx = ph;
    end

    // Transitions: quiet leaves at once, running states only on their wrap edge.
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_HIZ:     mode_nx = sel_to_mode(sel_q);
            MODE_THIRD:   if (wrap) mode_nx = sel_to_mode(sel_q);
            MODE_QUARTER: if (wrap) mode_nx = sel_to_mode(sel_q);
            MODE_REFTEST: if (wrap) mode_nx = sel_to_mode(sel_q);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= MODE_HIZ;
            ph    <= '0;
            sel_q <= 3'b000;
            en48  <= 1'b0;
        end else begin
            mode  <= mode_nx;
            ph    <= ph_nx;
            sel_q <= sel;
            if (realign)
                en48 <= sel_q[0];
        end
    end
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
    import clkdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  mode_e           mode_nx,
    input  logic [PH_W-1:0] ph_nx,
    output taps_t           taps
);
    taps_t q;
    logic  odd_q;
    logic  gfx_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            odd_q <= 1'b0;
        end else begin
            q     <= taps_at(mode_nx, ph_nx);
            odd_q <= (mode_nx == MODE_THIRD);
        end
    end

    // Half-cycle stretch for the divide-by-three graphics clock.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            gfx_lo <= 1'b0;
        else
            gfx_lo <= q.gfx & odd_q;
    end

    always_comb begin
        taps     = q;
        taps.gfx = q.gfx | gfx_lo;
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ref_in,
    output logic       cpu_clk,
    output logic       cpu_half,
    output logic       gfx_clk,
    output logic       pci_clk,
    output logic       apic_clk,
    output logic       ref_out,
    output logic       core_oe,
    output logic       usb48_oe,
    output logic       usb48_byp,
    output logic       usb48_tclk
);
    logic            ref_rise;
    mode_e           mode;
    mode_e           mode_nx;
    logic [PH_W-1:0] ph_nx;
    logic            en48;
    taps_t           taps;

    clkdiv_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rise   (ref_rise)
    );

    clkdiv_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .ref_rise (ref_rise),
        .mode     (mode),
        .mode_nx  (mode_nx),
        .ph_nx    (ph_nx),
        .en48     (en48)
    );

    clkdiv_wave u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_nx (mode_nx),
        .ph_nx   (ph_nx),
        .taps    (taps)
    );

    always_comb begin
        cpu_clk    = taps.cpu;
        cpu_half   = taps.half;
        gfx_clk    = taps.gfx;
        pci_clk    = taps.pci;
        apic_clk   = taps.apic;
        core_oe    = (mode != MODE_HIZ);
        usb48_byp  = (mode == MODE_REFTEST);
        usb48_oe   = core_oe & (usb48_byp | en48);
        usb48_tclk = usb48_byp & taps.cpu;
        ref_out    = core_oe & ref_in;
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_clk,
    input logic cpu_half,
    input logic gfx_clk,
    input logic pci_clk,
    input logic apic_clk,
    input logic core_oe,
    input logic usb48_oe,
    input logic usb48_byp
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!cpu_clk && !cpu_half && !gfx_clk && !pci_clk
                                      && !apic_clk && !core_oe && !usb48_oe)
                else $error("reset state not quiet");
        end
    end

    p_hiz_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_oe |-> (!cpu_clk && !cpu_half && !gfx_clk && !pci_clk && !apic_clk && !usb48_oe))
        else $error("quiet mode drives a clock");

    p_cpu_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_oe && $past(core_oe) && !usb48_byp && !$past(usb48_byp))
            |-> (cpu_clk != $past(cpu_clk)))
        else $error("processor clock missed a toggle");

    p_edges_on_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_half) || $rose(pci_clk) || $rose(apic_clk)) |-> $rose(cpu_clk))
        else $error("derived clock rose off a processor edge");

    p_usb_needs_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
        usb48_oe |-> core_oe)
        else $error("48 MHz enabled in quiet mode");

    p_entry_phase0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_oe) |-> (cpu_clk && cpu_half && gfx_clk && pci_clk && apic_clk))
        else $error("mode entered off phase 0");
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_clk   (cpu_clk),
    .cpu_half  (cpu_half),
    .gfx_clk   (gfx_clk),
    .pci_clk   (pci_clk),
    .apic_clk  (apic_clk),
    .core_oe   (core_oe),
    .usb48_oe  (usb48_oe),
    .usb48_byp (usb48_byp)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [2:0] sel = 3'b000;
    logic       ref_in = 1'b0;
    logic       cpu_clk, cpu_half, gfx_clk, pci_clk, apic_clk;
    logic       ref_out, core_oe, usb48_oe, usb48_byp, usb48_tclk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    clkdiv_bank dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ref_in(ref_in),
        .cpu_clk(cpu_clk), .cpu_half(cpu_half), .gfx_clk(gfx_clk),
        .pci_clk(pci_clk), .apic_clk(apic_clk), .ref_out(ref_out),
        .core_oe(core_oe), .usb48_oe(usb48_oe), .usb48_byp(usb48_byp),
        .usb48_tclk(usb48_tclk)
    );

    function automatic logic [4:0] vec();
        return {cpu_clk, cpu_half, gfx_clk, pci_clk, apic_clk};
    endfunction

    // Expected levels at a quarter cycle after the rising edge of phase c.
    function automatic logic [4:0] exp_taps(bit fam3, int c);
        if (fam3)
            return {(c % 2) == 0, (c % 4) < 2, (c % 3) != 2, (c % 6) < 3, c < 6};
        else
            return {(c % 2) == 0, (c % 4) < 2, (c % 4) < 2, (c % 8) < 4, c < 8};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic smp();
        @(posedge clk);
        #5;
    endtask

    task automatic run_check(string req, bit fam3, int c0, int n, bit e48);
        int c = c0;
        for (int i = 0; i < n; i++) begin
            smp();
            chk(req, {3'b0, vec()}, {3'b0, exp_taps(fam3, c)});
            chk("R7", {7'b0, usb48_oe}, {7'b0, e48});
            if (fam3) begin
                #10;
                chk("R5", {7'b0, gfx_clk}, {7'b0, (c % 3) == 0});
            end
            c = (c + 1) % (fam3 ? 12 : 16);
        end
    endtask

    task automatic t_reset();
        #1 rst_n = 1'b0;
        sel = 3'b011;
        for (int i = 0; i < 3; i++) begin
            smp();
            chk("R1", {1'b0, vec(), core_oe, usb48_oe}, 8'h00);
        end
        sel = 3'b000;
        rst_n = 1'b1;
    endtask

    task automatic t_hiz_idle();
        ref_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            smp();
            chk("R2", {vec(), core_oe, usb48_oe, ref_out}, 8'h00);
        end
        ref_in = 1'b0;
    endtask

    task automatic t_enter(logic [2:0] code, bit byp);
        sel = code;
        smp();
        chk("R10", {7'b0, core_oe}, 8'h00);
        smp();
        chk("R10", {7'b0, core_oe}, 8'h01);
        chk("R6", {3'b0, vec()}, 8'h1f);
        chk("R8", {7'b0, usb48_byp}, {7'b0, byp});
    endtask

    task automatic t_families();
        t_enter(3'b111, 1'b0);
        run_check("R3", 1'b0, 1, 4, 1'b1);
        ref_in = 1'b1;
        #1 chk("R9", {6'b0, core_oe, ref_out}, 8'h03);
        ref_in = 1'b0;
        sel = 3'b010;                       // mid-period change
        run_check("R10", 1'b0, 5, 11, 1'b1);
        run_check("R4", 1'b1, 0, 12, 1'b0);
        sel = 3'b111;                       // arrives in the last phase
        run_check("R11", 1'b1, 0, 12, 1'b0);
        run_check("R11", 1'b0, 0, 4, 1'b1);
        sel = 3'b000;
        run_check("R10", 1'b0, 4, 12, 1'b1);
        smp();
        chk("R2", {1'b0, vec(), core_oe, usb48_oe}, 8'h00);
    endtask

    task automatic t_reftest();
        logic [5:0] prev;
        logic [5:0] cur;
        int rises [6];
        t_enter(3'b100, 1'b1);
        chk("R8", {6'b0, usb48_oe, usb48_tclk}, 8'h03);
        prev = {vec(), usb48_tclk};
        for (int k = 0; k < 6; k++) rises[k] = 0;
        for (int i = 0; i < 266; i++) begin
            smp();
            cur = {vec(), usb48_tclk};
            for (int k = 0; k < 6; k++)
                if (cur[k] && !prev[k]) rises[k]++;
            prev = cur;
            if (i == 3) chk("R9", {7'b0, ref_out}, {7'b0, ref_in});
            ref_in = (i < 255) && ((i % 8) < 4);
        end
        // cur bits: 5 cpu, 4 half, 3 gfx, 2 pci, 1 apic, 0 tclk
        chk("R8", rises[5][7:0], 8'd16);
        chk("R8", rises[4][7:0], 8'd8);
        chk("R8", rises[3][7:0], 8'd8);
        chk("R8", rises[2][7:0], 8'd4);
        chk("R8", rises[1][7:0], 8'd2);
        chk("R8", rises[0][7:0], 8'd16);
        chk("R8", {3'b0, vec()}, 8'h1f);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hiz_idle();
        t_families();
        t_reftest();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule